// File: doc/BRIEF.md
# DDR Command Timing Guard

This block watches the command bus between a memory controller and a DDR SDRAM. Each cycle it decodes the command on chip select, row strobe, column strobe and write enable, together with the bank address and the auto-precharge/all-banks bit. It keeps a small timer set for every bank and one shared read-to-write timer. A command that breaks a spacing rule is reported one clock later as a one-cycle violation pulse. The pulse carries a rule code and the bank involved.

A flagged command counts as rejected, so it leaves every timer and row state untouched. A per-bank ready vector shows which banks are out of their precharge lockout, and the controller can use it to hold off. CAS latency, burst length, activate-to-column delay, precharge time and write recovery are parameters. A speed-grade input adds one clock to the read-to-write turnaround when set.

Command encodings (chip select, row strobe, column strobe, write enable, all active low): activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode register set 0000, no-op 0111, burst stop 0110. Chip select high is a deselect.

Rule codes on `viol_code`:
- 0: none
- 1: bank in lockout
- 2: activate-to-column too soon
- 3: read-to-write too soon
- 4: column access to a bank with no open row
- 5: activate to a bank whose row is already open
- 6: bank not idle for a mode set or refresh

A command in cycle n that starts a window of V clocks makes the rule-bound command legal again from cycle n+V.

Top module: `ddr_cmd_guard`

## Requirements
- R1: After reset no violation is reported, every `bank_ready` bit is 1, and every bank is treated as idle with no open row.
- R2: A read or write to a bank earlier than TRCD clocks after that bank's activate gives code 2 for that bank; at exactly TRCD clocks it is legal.
- R3: A read or write to a bank with no open row gives code 4. An activate to a bank with an open row gives code 5.
- R4: A write issued sooner than CL+BL/2 clocks after the last legal read (on any bank) gives code 3, or sooner than CL+BL/2+1 clocks when `fast_grade` was 1 at that read.
- R5: A precharge with `a10`=0 closes the addressed bank and locks it for TRP clocks. Any command to a locked bank gives code 1.
- R6: A precharge with `a10`=1 closes all banks and locks each for TRP clocks, whatever `ba` holds. If any bank is locked, it gives code 1 with the lowest locked bank.
- R7: A read with `a10`=1 closes its bank and locks it for BL/2+TRP clocks.
- R8: A write with `a10`=1 closes its bank and locks it for BL/2+1+TWR+TRP clocks.
- R9: A mode register set or refresh while any bank is open or locked gives code 6 with the lowest such bank.
- R10: `viol`, `viol_code` and `viol_bank` are registered in the cycle after the command and last one clock per offending command. `viol_code` is 0 and `viol_bank` is 0 when `viol` is 0. A flagged command changes no bank or turnaround state.
- R11: When several rules fail, the reported code follows the order lockout, then row state (codes 4/5), then activate-to-column, then read-to-write.
- R12: `bank_ready[b]` is 0 exactly while bank b's lockout timer is running, and it follows the state after the command of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_grade | input | 1 | 1 adds one clock to read-to-write spacing |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BAW | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks bit |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Broken rule code |
| viol_bank | output | BAW | Bank involved |
| bank_ready | output | NBANK | Per-bank lockout finished |

## Verification
Most internal faults show up at the ports within one command of the state that went wrong. A stuck or miscounted lockout timer shows one cycle after the precharge, as a wrong `bank_ready` bit. It also shows as a lockout flag one clock early, or as a missing flag one clock late, at the boundary activate. A lost open-row bit turns the next column access into code 4. A wrong turnaround load only appears at the first write placed exactly at the boundary. For that reason the stimulus puts commands at window edge minus one and at the window edge, for every window.

// File: rtl/ddr_guard_pkg.sv
package ddr_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_MRS  = 3'd6,
        CMD_BST  = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        V_NONE   = 3'd0,
        V_LOCK   = 3'd1,
        V_RCD    = 3'd2,
        V_RTW    = 3'd3,
        V_CLOSED = 3'd4,
        V_OPEN   = 3'd5,
        V_BUSY   = 3'd6
    } viol_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_guard_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_MRS;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer #(
    parameter int TRCD = 6,
    parameter int LW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_act,
    input  logic          evt_close,
    input  logic [LW-1:0] close_val,
    output logic          open_o,
    output logic          lock_busy_o,
    output logic          rcd_busy_o
);
    localparam int RW = $clog2(TRCD + 1);

    typedef struct packed {
        logic          open;
        logic [LW-1:0] lock;
        logic [RW-1:0] rcd;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.lock != '0) st_d.lock = st_q.lock - 1'b1;
        if (st_q.rcd  != '0) st_d.rcd  = st_q.rcd  - 1'b1;
        if (evt_act) begin
            st_d.open = 1'b1;
            st_d.rcd  = RW'(TRCD - 1);
        end
        if (evt_close) begin
            st_d.open = 1'b0;
            st_d.lock = close_val;
            st_d.rcd  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o      = st_q.open;
    assign lock_busy_o = (st_q.lock != '0);
    assign rcd_busy_o  = (st_q.rcd != '0);

    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        evt_act |=> open_o);
    a_r5_locked_is_closed: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy_o |-> !open_o);
    a_r12_lock_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_busy_o && !evt_close) |=> (st_q.lock == $past(st_q.lock) - 1'b1));
    a_r10_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_act && evt_close));
endmodule

// File: rtl/ddr_rtw_timer.sv
module ddr_rtw_timer #(
    parameter int CL = 4,
    parameter int BL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fast,
    output logic busy_o
);
    localparam int SPAN_SLOW = CL + BL / 2;
    localparam int SPAN_FAST = SPAN_SLOW + 1;
    localparam int TW        = $clog2(SPAN_FAST + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        if (load)        cnt_d = fast ? TW'(SPAN_FAST - 1) : TW'(SPAN_SLOW - 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    a_r4_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy_o);
    a_r4_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ddr_cmd_guard.sv
module ddr_cmd_guard
    import ddr_guard_pkg::*;
#(
    parameter int CL    = 4,
    parameter int BL    = 4,
    parameter int TRCD  = 6,
    parameter int TRP   = 3,
    parameter int TWR   = 2,
    parameter int NBANK = 4,
    localparam int BAW  = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_grade,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [BAW-1:0]   ba,
    input  logic             a10,
    output logic             viol,
    output logic [2:0]       viol_code,
    output logic [BAW-1:0]   viol_bank,
    output logic [NBANK-1:0] bank_ready
);
    localparam int LOCK_RDA = BL / 2 + TRP;
    localparam int LOCK_WRA = BL / 2 + 1 + TWR + TRP;
    localparam int LW       = $clog2(LOCK_WRA + 1);

    typedef struct packed {
        logic           viol;
        viol_e          code;
        logic [BAW-1:0] bank;
    } rep_t;

    cmd_e             cmd;
    logic [NBANK-1:0] open_v, lock_v, rcd_v, busy_v;
    logic [NBANK-1:0] act_ev, close_ev;
    logic [LW-1:0]    close_val [NBANK];
    logic             rtw_busy, rtw_load, legal;
    logic [BAW-1:0]   first_lock, first_busy;
    viol_e            code;
    logic [BAW-1:0]   cbank;
    rep_t             rep_d, rep_q;

    ddr_cmd_decode u_dec (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
    );

    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        ddr_bank_timer #(.TRCD(TRCD), .LW(LW)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt_act     (act_ev[gb]),
            .evt_close   (close_ev[gb]),
            .close_val   (close_val[gb]),
            .open_o      (open_v[gb]),
            .lock_busy_o (lock_v[gb]),
            .rcd_busy_o  (rcd_v[gb])
        );
    end

    ddr_rtw_timer #(.CL(CL), .BL(BL)) u_rtw (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (rtw_load),
        .fast   (fast_grade),
        .busy_o (rtw_busy)
    );

    assign busy_v = open_v | lock_v;

    always_comb begin
        first_lock = '0;
        first_busy = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (lock_v[i]) first_lock = BAW'(i);
            if (busy_v[i]) first_busy = BAW'(i);
        end
    end

    // rule check, in priority order: lockout, row state, tRCD, turnaround
    always_comb begin
        code  = V_NONE;
        cbank = ba;
        unique case (cmd)
            CMD_ACT: begin
                if (lock_v[ba])      code = V_LOCK;
                else if (open_v[ba]) code = V_OPEN;
            end
            CMD_RD, CMD_WR: begin
                if (lock_v[ba])                     code = V_LOCK;
                else if (!open_v[ba])               code = V_CLOSED;
                else if (rcd_v[ba])                 code = V_RCD;
                else if (cmd == CMD_WR && rtw_busy) code = V_RTW;
            end
            CMD_PRE: begin
                if (a10) begin
                    if (|lock_v) begin
                        code  = V_LOCK;
                        cbank = first_lock;
                    end
                end else if (lock_v[ba]) begin
                    code = V_LOCK;
                end
            end
            CMD_REF, CMD_MRS: begin
                if (|busy_v) begin
                    code  = V_BUSY;
                    cbank = first_busy;
                end
            end
            default: code = V_NONE;
        endcase
        legal = (code == V_NONE);
    end

    always_comb begin
        rtw_load = legal && (cmd == CMD_RD);
        for (int b = 0; b < NBANK; b++) begin
            act_ev[b]    = legal && (cmd == CMD_ACT) && (ba == BAW'(b));
            close_ev[b]  = 1'b0;
            close_val[b] = '0;
            if (legal) begin
                if (cmd == CMD_RD && a10 && ba == BAW'(b)) begin
                    close_ev[b]  = 1'b1;
                    close_val[b] = LW'(LOCK_RDA - 1);
                end else if (cmd == CMD_WR && a10 && ba == BAW'(b)) begin
                    close_ev[b]  = 1'b1;
                    close_val[b] = LW'(LOCK_WRA - 1);
                end else if (cmd == CMD_PRE && (a10 || ba == BAW'(b))) begin
                    close_ev[b]  = 1'b1;
                    close_val[b] = LW'(TRP - 1);
                end
            end
        end
    end

    always_comb begin
        rep_d.viol = !legal;
        rep_d.code = code;
        rep_d.bank = legal ? '0 : cbank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rep_q <= '{viol: 1'b0, code: V_NONE, bank: '0};
        else        rep_q <= rep_d;
    end

    assign viol       = rep_q.viol;
    assign viol_code  = rep_q.code;
    assign viol_bank  = rep_q.bank;
    assign bank_ready = ~lock_v;

    a_r10_flag_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (viol_code != 3'd0));
    a_r10_quiet_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !viol |-> (viol_code == 3'd0 && viol_bank == '0));
    a_r9_busy_blocks_mrs: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS && |busy_v) |=> (viol && viol_code == 3'd6));
    a_r6_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE && a10 && !(|lock_v)) |=> (open_v == '0 && lock_v == '1));
endmodule

// File: tb/ddr_cmd_guard_test.sv
module ddr_cmd_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fast = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic       viol;
    logic [2:0] vcode;
    logic [1:0] vbank;
    logic [3:0] rdy;

    localparam logic [3:0] P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                           P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000,
                           P_NOP = 4'b0111;

    typedef struct {
        logic [2:0] code;
        logic [1:0] bank;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    ddr_cmd_guard uut (
        .clk (clk), .rst_n (rst_n), .fast_grade (fast),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .a10 (a10),
        .viol (viol), .viol_code (vcode), .viol_bank (vbank), .bank_ready (rdy)
    );

    // driver: one command per cycle, expected report pushed to the scoreboard
    task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic ap,
                         input logic [2:0] ec, input logic [1:0] eb, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        {cs_n, ras_n, cas_n, we_n} = p;
        ba  = b;
        a10 = ap;
        e.code = ec;
        e.bank = eb;
        e.tag  = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
        {cs_n, ras_n, cas_n, we_n} = P_NOP;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(P_NOP, 2'd0, 1'b0, 3'd0, 2'd0, "R10 idle");
    endtask

    task automatic chk_rdy(input logic [3:0] exp, input string tag);
        n_chk++;
        if (rdy !== exp) begin
            n_bad++;
            $display("FAIL %s: bank_ready got %b expected %b", tag, rdy, exp);
        end
    endtask

    // monitor: compares the report one cycle after each command
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (viol !== (e.code != 3'd0) || vcode !== e.code ||
                (e.code != 3'd0 && vbank !== e.bank)) begin
                n_bad++;
                $display("FAIL %s: got viol=%0b code=%0d bank=%0d expected code=%0d bank=%0d",
                         e.tag, viol, vcode, vbank, e.code, e.bank);
            end
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (viol !== 1'b0 || vcode !== 3'd0) begin
            n_bad++;
            $display("FAIL R1: viol=%0b code=%0d expected 0/0", viol, vcode);
        end
        chk_rdy(4'hF, "R1 reset ready");

        // R3 column access with no open row
        issue(P_RD, 2'd0, 1'b0, 3'd4, 2'd0, "R3 read closed bank");
        // R2 activate-to-column
        issue(P_ACT, 2'd0, 1'b0, 3'd0, 2'd0, "R2 act b0");
        issue(P_RD, 2'd0, 1'b0, 3'd2, 2'd0, "R2 early read");
        idle(4);
        issue(P_RD, 2'd0, 1'b0, 3'd0, 2'd0, "R2 read at tRCD");
        // R4 turnaround, slow grade: 6 clocks
        issue(P_ACT, 2'd1, 1'b0, 3'd0, 2'd0, "R2 act b1");
        issue(P_WR, 2'd0, 1'b0, 3'd3, 2'd0, "R4 early write");
        idle(3);
        issue(P_WR, 2'd0, 1'b0, 3'd0, 2'd0, "R4 write at turnaround");
        issue(P_ACT, 2'd0, 1'b0, 3'd5, 2'd0, "R3 act open bank");
        // R5 single-bank precharge
        issue(P_PRE, 2'd0, 1'b0, 3'd0, 2'd0, "R5 pre b0");
        chk_rdy(4'b1110, "R12 b0 locked");
        issue(P_ACT, 2'd0, 1'b0, 3'd1, 2'd0, "R5 act in lockout");
        issue(P_RD, 2'd0, 1'b0, 3'd1, 2'd0, "R11 lock beats closed");
        issue(P_ACT, 2'd0, 1'b0, 3'd0, 2'd0, "R5 R10 act after tRP");
        chk_rdy(4'hF, "R12 b0 released");
        // R9 mode set while busy
        issue(P_MRS, 2'd0, 1'b0, 3'd6, 2'd0, "R9 mrs with open rows");
        // R6 precharge all, bank field ignored
        issue(P_PRE, 2'd3, 1'b1, 3'd0, 2'd0, "R6 pre all");
        chk_rdy(4'h0, "R6 R12 all locked");
        issue(P_REF, 2'd0, 1'b0, 3'd6, 2'd0, "R9 refresh in lockout");
        idle(1);
        issue(P_REF, 2'd0, 1'b0, 3'd0, 2'd0, "R9 refresh when idle");
        chk_rdy(4'hF, "R6 all released");
        issue(P_RD, 2'd1, 1'b0, 3'd4, 2'd1, "R6 b1 closed by pre all");
        // R7 read with auto-precharge: 5 clocks
        issue(P_ACT, 2'd2, 1'b0, 3'd0, 2'd0, "R7 act b2");
        idle(5);
        issue(P_RD, 2'd2, 1'b1, 3'd0, 2'd0, "R7 read ap");
        chk_rdy(4'b1011, "R7 R12 b2 locked");
        idle(3);
        issue(P_ACT, 2'd2, 1'b0, 3'd1, 2'd2, "R7 act one early");
        issue(P_ACT, 2'd2, 1'b0, 3'd0, 2'd0, "R7 act at window end");
        // R8 write with auto-precharge: 8 clocks
        idle(5);
        issue(P_WR, 2'd2, 1'b1, 3'd0, 2'd0, "R8 write ap");
        chk_rdy(4'b1011, "R8 b2 locked");
        idle(6);
        issue(P_ACT, 2'd2, 1'b0, 3'd1, 2'd2, "R8 act one early");
        issue(P_ACT, 2'd2, 1'b0, 3'd0, 2'd0, "R8 act at window end");
        // R4 fast grade: 7 clocks
        fast = 1'b1;
        issue(P_ACT, 2'd3, 1'b0, 3'd0, 2'd0, "R4 act b3");
        idle(5);
        issue(P_RD, 2'd3, 1'b0, 3'd0, 2'd0, "R4 fast read");
        idle(5);
        issue(P_WR, 2'd3, 1'b0, 3'd3, 2'd3, "R4 fast write one early");
        issue(P_WR, 2'd3, 1'b0, 3'd0, 2'd0, "R4 fast write at turnaround");
        // R11 tRCD reported over turnaround
        issue(P_ACT, 2'd1, 1'b0, 3'd0, 2'd0, "R11 act b1");
        issue(P_RD, 2'd3, 1'b0, 3'd0, 2'd0, "R11 read b3");
        issue(P_WR, 2'd1, 1'b0, 3'd2, 2'd1, "R11 rcd over rtw");
        idle(1);
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule